// File: doc/BRIEF.md
# Receive Frame Store and Notify Engine

This block sits between a MAC receive path and a paged packet memory. It accepts frames whose destination address has already been matched, but only while a receive-enable control input is high. When a frame begins, it asks a packet allocator for a packet number. As the frame grows past each page boundary, it asks for further pages. Payload words are written into the packet at consecutive word offsets, starting after two reserved header words. When the last beat arrives, the engine fills in the two header words: a status word and the payload byte count.

A frame is published to the host only when its CRC is known to be good. Publishing means pushing the packet number onto a 16-deep receive queue. A frame with a bad CRC, a refused page request, an oversize length, or a full queue at end of frame is dropped instead, and its packet number is handed back to the allocator. A receive interrupt stays high while the queue holds anything. The host reads the packet number at the head of the queue. It then issues a remove command, which pops that entry and returns the packet to the allocator.

The input stream has no back-pressure. Frames must be separated by at least two idle cycles so the header writes can complete. Page size must be a power of two and at least four words.

Top module: `rxs_frame_store`

## Requirements
- R1: A start-of-frame beat that arrives while `rx_enable` is low causes no allocation request, no memory write and no release, and the rest of that frame is ignored.
- R2: An accepted start-of-frame beat raises `alloc_req` with `alloc_new`=1 in the same cycle. A later payload beat whose target offset is a nonzero multiple of `PAGE_WORDS` raises `alloc_req` with `alloc_new`=0 in the same cycle.
- R3: Payload beat k of a frame is written in its own cycle to word offset 2+k of the granted packet, with the beat's data.
- R4: In the cycle after the last beat of a stored frame, the status word is written to offset 0. Its bit 0 is the odd-length flag, and its bit 15 is the CRC-error flag, which is clear for every stored frame. In the next cycle the byte count, 2×(payload words) − odd, is written to offset 1.
- R5: A refused page request drops the frame. `drop_rel_valid` pulses with its packet number in that cycle, and nothing more is written until the frame ends. A refused first request writes nothing and releases nothing.
- R6: A last beat with `in_crc_ok`=0 pulses `drop_rel_valid` with the packet number in that cycle. No header is written and nothing is queued.
- R7: If the queue holds 16 entries at the last beat of a good frame, the frame is dropped and released in that cycle and not queued.
- R8: A stored frame's packet number enters the queue at the edge that ends its byte-count write. `rx_irq` is high exactly while the queue is non-empty.
- R9: `host_remove` with a non-empty queue pulses `host_rel_valid` with the head packet number in that cycle and pops it. With an empty queue it has no effect.
- R10: Input beats that arrive during the two header-write cycles are ignored.
- R11: A beat that would land at offset `PAGE_WORDS`×`MAX_PAGES` or beyond is an overrun. The frame is released in that cycle with no allocation request.
- R12: `top_pkt` presents packet numbers in the order their frames completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Receive enable; sampled at start of frame |
| in_valid | input | 1 | Input beat valid |
| in_sof | input | 1 | Beat is the first of a frame |
| in_eof | input | 1 | Beat is the last of a frame |
| in_odd | input | 1 | Last beat carries one byte only (valid with `in_eof`) |
| in_crc_ok | input | 1 | Frame CRC good (valid with `in_eof`) |
| in_data | input | DATA_W | Payload word |
| alloc_req | output | 1 | Allocation request, answered in the same cycle |
| alloc_new | output | 1 | 1: new packet; 0: extra page for the current packet |
| alloc_ok | input | 1 | Allocator grants the request |
| alloc_pkt | input | PKT_W | Granted packet number for a new packet |
| mem_we | output | 1 | Packet memory write strobe |
| mem_pkt | output | PKT_W | Packet being written |
| mem_off | output | OFF_W | Word offset inside the packet |
| mem_wdata | output | DATA_W | Write data |
| drop_rel_valid | output | 1 | Release a dropped frame's packet |
| drop_rel_pkt | output | PKT_W | Packet number to release on drop |
| host_remove | input | 1 | Host command: remove and release head of queue |
| rx_irq | output | 1 | Receive interrupt, high while queue non-empty |
| top_pkt | output | PKT_W | Packet number at head of queue |
| host_rel_valid | output | 1 | Release caused by a host remove |
| host_rel_pkt | output | PKT_W | Packet number released by the host remove |

## Verification
The bench targets several corner cases:

- **Page-boundary request.** A frame crosses a page edge. A design that requested pages at the wrong offset, or forgot them, would show a missing or misplaced `alloc_req`.
- **Refusals and bad CRC.** A page refusal in mid-frame, a refusal at the very first word, and a bad CRC all exercise the drop path. A wrong design would leak a packet number, or would publish a frame the host must never see.
- **Oversize frame.** A frame is long enough to hit the capacity limit. An off-by-one limit would write past the packet.
- **Header window and queue limits.** A new frame starts during the header writes. The queue is filled to 16, and a 17th frame must be dropped. Removes are issued on an empty queue. These cases catch header corruption, queue overflow and phantom releases.

// File: rtl/rxs_pkg.sv
// Package: shared state encoding and header field layout for the receive
// frame store. Assumes nothing beyond being compiled before its users.
package rxs_pkg;

    // Write-control sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RECV = 3'd1,
        ST_DROP = 3'd2,
        ST_HDR0 = 3'd3,
        ST_HDR1 = 3'd4
    } rxs_state_t;

    // Number of header words reserved ahead of the payload.
    localparam int HDR_WORDS    = 2;
    // Status word field positions.
    localparam int STAT_ODD_BIT = 0;
    localparam int STAT_CRC_BIT = 15;

endpackage

// File: rtl/rxs_pkt_fifo.sv
// Module: rxs_pkt_fifo
// Holds packet numbers of stored frames in arrival order. Head entry is
// visible combinationally. A push while full and a pop while empty are
// ignored. Assumes DEPTH >= 2.
module rxs_pkt_fifo #(
    parameter int W     = 5,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          do_push;
    logic          do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rd_ptr];

    // Write the incoming packet number into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= din;
        end
    end

    // Advance pointers and occupancy on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + AW'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + AW'(1);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

    // R8
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

endmodule

// File: rtl/rxs_write_ctrl.sv
// Module: rxs_write_ctrl
// Sequences one receive frame at a time. It allocates a packet at start of
// frame and requests extra pages at page edges. It writes payload from
// offset HDR_WORDS upward, then writes the status and byte-count header
// words, and hands the packet number to the queue. Failed frames are
// released instead. Assumes PAGE_WORDS is a power of two >= 4, the
// allocator answers in the same cycle, and frames are at least two idle
// cycles apart.
module rxs_write_ctrl
    import rxs_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int PKT_W      = 5,
    parameter int PAGE_WORDS = 8,
    parameter int MAX_PAGES  = 4,
    localparam int CAP       = PAGE_WORDS * MAX_PAGES,
    localparam int OFF_W     = $clog2(CAP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_odd,
    input  logic              in_crc_ok,
    input  logic [DATA_W-1:0] in_data,
    output logic              alloc_req,
    output logic              alloc_new,
    input  logic              alloc_ok,
    input  logic [PKT_W-1:0]  alloc_pkt,
    output logic              mem_we,
    output logic [PKT_W-1:0]  mem_pkt,
    output logic [OFF_W-1:0]  mem_off,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              drop_rel_valid,
    output logic [PKT_W-1:0]  drop_rel_pkt,
    input  logic              fifo_full,
    output logic              push_valid,
    output logic [PKT_W-1:0]  push_pkt
);
    localparam int PG_W  = $clog2(PAGE_WORDS);
    localparam int CNT_W = OFF_W + 2;
    localparam logic [OFF_W:0] CAP_V     = (OFF_W + 1)'(CAP);
    localparam logic [OFF_W:0] FIRST_OFF = (OFF_W + 1)'(HDR_WORDS);

    rxs_state_t        state_q, state_d;
    logic [PKT_W-1:0]  pkt_q, pkt_d;
    logic [OFF_W:0]    off_q, off_d;
    logic              odd_q, odd_d;
    logic              crc_bad_q, crc_bad_d;

    logic              end_beat;
    logic              overrun;
    logic              page_edge;
    logic              room;
    logic [OFF_W:0]    word_cnt;
    logic [CNT_W-1:0]  byte_cnt;
    logic [DATA_W-1:0] status_word;

    // Offset position flags for the beat under consideration.
    assign page_edge = (off_q[PG_W-1:0] == '0);
    assign room      = (off_q < CAP_V);

    // Header field values built from the captured end-of-frame state.
    assign word_cnt  = off_q - FIRST_OFF;
    assign byte_cnt  = {1'b0, word_cnt, 1'b0} - CNT_W'(odd_q);

    // Assemble the status word from its individual flags.
    always_comb begin
        status_word               = '0;
        status_word[STAT_ODD_BIT] = odd_q;
        status_word[STAT_CRC_BIT] = crc_bad_q;
    end

    // Next-state and output decode for the frame sequencer.
    always_comb begin
        state_d        = state_q;
        pkt_d          = pkt_q;
        off_d          = off_q;
        odd_d          = odd_q;
        crc_bad_d      = crc_bad_q;
        alloc_req      = 1'b0;
        alloc_new      = 1'b0;
        mem_we         = 1'b0;
        mem_pkt        = pkt_q;
        mem_off        = off_q[OFF_W-1:0];
        mem_wdata      = in_data;
        drop_rel_valid = 1'b0;
        drop_rel_pkt   = pkt_q;
        push_valid     = 1'b0;
        push_pkt       = pkt_q;
        end_beat       = 1'b0;
        overrun        = 1'b0;

        case (state_q)
            ST_IDLE: begin
                if (in_valid && in_sof && rx_enable) begin
                    alloc_req = 1'b1;
                    alloc_new = 1'b1;
                    if (alloc_ok) begin
                        mem_we   = 1'b1;
                        mem_pkt  = alloc_pkt;
                        mem_off  = FIRST_OFF[OFF_W-1:0];
                        pkt_d    = alloc_pkt;
                        off_d    = FIRST_OFF + (OFF_W + 1)'(1);
                        state_d  = ST_RECV;
                        end_beat = in_eof;
                    end else begin
                        state_d = in_eof ? ST_IDLE : ST_DROP;
                    end
                end
            end
            ST_RECV: begin
                if (in_valid) begin
                    if (!room) begin
                        overrun = 1'b1;
                    end else begin
                        if (page_edge) begin
                            alloc_req = 1'b1;
                        end
                        if (page_edge && !alloc_ok) begin
                            overrun = 1'b1;
                        end else begin
                            mem_we   = 1'b1;
                            off_d    = off_q + (OFF_W + 1)'(1);
                            end_beat = in_eof;
                        end
                    end
                end
            end
            ST_DROP: begin
                if (in_valid && in_eof) begin
                    state_d = ST_IDLE;
                end
            end
            ST_HDR0: begin
                mem_we    = 1'b1;
                mem_off   = '0;
                mem_wdata = status_word;
                state_d   = ST_HDR1;
            end
            ST_HDR1: begin
                mem_we     = 1'b1;
                mem_off    = OFF_W'(1);
                mem_wdata  = DATA_W'(byte_cnt);
                push_valid = 1'b1;
                state_d    = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase

        if (overrun) begin
            drop_rel_valid = 1'b1;
            drop_rel_pkt   = pkt_q;
            state_d        = in_eof ? ST_IDLE : ST_DROP;
        end

        if (end_beat) begin
            crc_bad_d = !in_crc_ok;
            odd_d     = in_odd;
            if (in_crc_ok && !fifo_full) begin
                state_d = ST_HDR0;
            end else begin
                drop_rel_valid = 1'b1;
                drop_rel_pkt   = pkt_d;
                state_d        = ST_IDLE;
            end
        end
    end

    // Sequencer registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pkt_q     <= '0;
            off_q     <= '0;
            odd_q     <= 1'b0;
            crc_bad_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            pkt_q     <= pkt_d;
            off_q     <= off_d;
            odd_q     <= odd_d;
            crc_bad_q <= crc_bad_d;
        end
    end

    // R1
    disabled_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !rx_enable) |-> (!alloc_req && !mem_we));

    // R4
    hdr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_off == '0) |=> (mem_we && mem_off == OFF_W'(1)));

    // R8
    push_after_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> $past(mem_we && mem_off == '0));

    // R6
    drop_not_published_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_rel_valid |=> !(mem_we && mem_off == '0));

    // R3
    payload_on_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_off >= FIRST_OFF[OFF_W-1:0]) |-> in_valid);

    // R10
    hdr_ignores_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR0 || state_q == ST_HDR1) |-> (!alloc_req && !drop_rel_valid));

endmodule

// File: rtl/rxs_frame_store.sv
// Module: rxs_frame_store
// Top of the receive frame store. It joins the frame write sequencer to the
// packet-number queue, drives the receive interrupt from queue occupancy,
// and serves the host's remove-and-release command. Assumes the same
// stream and allocator rules as rxs_write_ctrl.
module rxs_frame_store #(
    parameter int DATA_W     = 16,
    parameter int PKT_W      = 5,
    parameter int PAGE_WORDS = 8,
    parameter int MAX_PAGES  = 4,
    parameter int FIFO_DEPTH = 16,
    localparam int OFF_W     = $clog2(PAGE_WORDS * MAX_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_odd,
    input  logic              in_crc_ok,
    input  logic [DATA_W-1:0] in_data,
    output logic              alloc_req,
    output logic              alloc_new,
    input  logic              alloc_ok,
    input  logic [PKT_W-1:0]  alloc_pkt,
    output logic              mem_we,
    output logic [PKT_W-1:0]  mem_pkt,
    output logic [OFF_W-1:0]  mem_off,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              drop_rel_valid,
    output logic [PKT_W-1:0]  drop_rel_pkt,
    input  logic              host_remove,
    output logic              rx_irq,
    output logic [PKT_W-1:0]  top_pkt,
    output logic              host_rel_valid,
    output logic [PKT_W-1:0]  host_rel_pkt
);
    logic             q_push;
    logic [PKT_W-1:0] q_push_pkt;
    logic             q_empty;
    logic             q_full;
    logic [PKT_W-1:0] q_head;

    rxs_write_ctrl #(
        .DATA_W     (DATA_W),
        .PKT_W      (PKT_W),
        .PAGE_WORDS (PAGE_WORDS),
        .MAX_PAGES  (MAX_PAGES)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_enable      (rx_enable),
        .in_valid       (in_valid),
        .in_sof         (in_sof),
        .in_eof         (in_eof),
        .in_odd         (in_odd),
        .in_crc_ok      (in_crc_ok),
        .in_data        (in_data),
        .alloc_req      (alloc_req),
        .alloc_new      (alloc_new),
        .alloc_ok       (alloc_ok),
        .alloc_pkt      (alloc_pkt),
        .mem_we         (mem_we),
        .mem_pkt        (mem_pkt),
        .mem_off        (mem_off),
        .mem_wdata      (mem_wdata),
        .drop_rel_valid (drop_rel_valid),
        .drop_rel_pkt   (drop_rel_pkt),
        .fifo_full      (q_full),
        .push_valid     (q_push),
        .push_pkt       (q_push_pkt)
    );

    rxs_pkt_fifo #(
        .W     (PKT_W),
        .DEPTH (FIFO_DEPTH)
    ) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   (q_push_pkt),
        .pop   (host_rel_valid),
        .dout  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    // Host-facing view of the queue and the remove-and-release path.
    assign rx_irq         = !q_empty;
    assign top_pkt        = q_head;
    assign host_rel_valid = host_remove && !q_empty;
    assign host_rel_pkt   = q_head;

    // R9
    host_release_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_remove && rx_irq) |-> (host_rel_valid && host_rel_pkt == top_pkt));

    // R8
    irq_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |=> rx_irq);

endmodule

// File: tb/tb_rxs_frame_store.sv
// Bench: behavioural queue-based model of the frame store, compared with
// the design on every clock.
module tb_rxs_frame_store;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int PKT_W  = 5;
    localparam int PAGE   = 8;
    localparam int MAXP   = 4;
    localparam int CAP    = PAGE * MAXP;
    localparam int DEPTH  = 16;
    localparam int OFF_W  = $clog2(CAP);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_enable = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_odd = 1'b0, in_crc_ok = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic alloc_req, alloc_new;
    logic alloc_ok = 1'b0;
    logic [PKT_W-1:0] alloc_pkt = '0;
    logic mem_we;
    logic [PKT_W-1:0] mem_pkt;
    logic [OFF_W-1:0] mem_off;
    logic [DATA_W-1:0] mem_wdata;
    logic drop_rel_valid;
    logic [PKT_W-1:0] drop_rel_pkt;
    logic host_remove = 1'b0;
    logic rx_irq;
    logic [PKT_W-1:0] top_pkt;
    logic host_rel_valid;
    logic [PKT_W-1:0] host_rel_pkt;

    int checks = 0;
    int failures = 0;
    string ctx = "R8";

    // Model state
    int m_mode = 0;   // 0 idle, 1 receive, 2 discard, 3 status, 4 count
    int m_pkt = 0, m_off = 0, m_odd = 0;
    int q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxs_frame_store dut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_odd(in_odd),
        .in_crc_ok(in_crc_ok), .in_data(in_data),
        .alloc_req(alloc_req), .alloc_new(alloc_new), .alloc_ok(alloc_ok),
        .alloc_pkt(alloc_pkt), .mem_we(mem_we), .mem_pkt(mem_pkt),
        .mem_off(mem_off), .mem_wdata(mem_wdata),
        .drop_rel_valid(drop_rel_valid), .drop_rel_pkt(drop_rel_pkt),
        .host_remove(host_remove), .rx_irq(rx_irq), .top_pkt(top_pkt),
        .host_rel_valid(host_rel_valid), .host_rel_pkt(host_rel_pkt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", tag, ctx, $time, act, exp);
        end
    endtask

    // One clock: drive inputs, compare outputs with the model, advance model.
    task automatic step(input bit v, input bit sof, input bit eof, input bit odd,
                        input bit crc, input int d, input bit aok, input int apkt,
                        input bit hrem);
        int e_areq, e_anew, e_we, e_off, e_wd, e_wpkt, e_drop, e_dpkt, e_hrel, e_hpkt;
        int n_mode, n_pkt, n_off, n_odd;
        bit end_beat, push, ok;
        @(negedge clk);
        in_valid = v; in_sof = sof; in_eof = eof; in_odd = odd; in_crc_ok = crc;
        in_data = DATA_W'(d); alloc_ok = aok; alloc_pkt = PKT_W'(apkt); host_remove = hrem;
        #1;
        e_areq = 0; e_anew = 0; e_we = 0; e_off = 0; e_wd = 0; e_wpkt = 0;
        e_drop = 0; e_dpkt = 0;
        n_mode = m_mode; n_pkt = m_pkt; n_off = m_off; n_odd = m_odd;
        end_beat = 0; push = 0;
        case (m_mode)
            0: if (v && sof && rx_enable) begin
                e_areq = 1; e_anew = 1;
                if (aok) begin
                    e_we = 1; e_off = 2; e_wd = d; e_wpkt = apkt;
                    n_pkt = apkt; n_off = 3; n_mode = 1; end_beat = eof;
                end else n_mode = eof ? 0 : 2;
            end
            1: if (v) begin
                if (m_off >= CAP) begin
                    e_drop = 1; e_dpkt = m_pkt; n_mode = eof ? 0 : 2;
                end else begin
                    ok = 1;
                    if (m_off % PAGE == 0) begin e_areq = 1; ok = aok; end
                    if (!ok) begin
                        e_drop = 1; e_dpkt = m_pkt; n_mode = eof ? 0 : 2;
                    end else begin
                        e_we = 1; e_off = m_off; e_wd = d; e_wpkt = m_pkt;
                        n_off = m_off + 1; end_beat = eof;
                    end
                end
            end
            2: if (v && eof) n_mode = 0;
            3: begin e_we = 1; e_off = 0; e_wd = m_odd; e_wpkt = m_pkt; n_mode = 4; end
            4: begin
                e_we = 1; e_off = 1; e_wd = 2 * (m_off - 2) - m_odd; e_wpkt = m_pkt;
                push = 1; n_mode = 0;
            end
            default: n_mode = 0;
        endcase
        if (end_beat) begin
            if (crc && q.size() < DEPTH) begin n_mode = 3; n_odd = odd; end
            else begin e_drop = 1; e_dpkt = n_pkt; n_mode = 0; end
        end
        e_hrel = (hrem && q.size() > 0) ? 1 : 0;
        e_hpkt = (q.size() > 0) ? q[0] : 0;

        chk("R2 alloc_req", int'(alloc_req), e_areq);
        if (e_areq != 0) chk("R2 alloc_new", int'(alloc_new), e_anew);
        chk("R3 mem_we", int'(mem_we), e_we);
        if (e_we != 0) begin
            chk(e_off < 2 ? "R4 mem_off" : "R3 mem_off", int'(mem_off), e_off);
            chk(e_off < 2 ? "R4 mem_wdata" : "R3 mem_wdata", int'(mem_wdata), e_wd);
            chk("R3 mem_pkt", int'(mem_pkt), e_wpkt);
        end
        chk("R6 drop_rel_valid", int'(drop_rel_valid), e_drop);
        if (e_drop != 0) chk("R5 drop_rel_pkt", int'(drop_rel_pkt), e_dpkt);
        chk("R8 rx_irq", int'(rx_irq), (q.size() > 0) ? 1 : 0);
        if (q.size() > 0) chk("R12 top_pkt", int'(top_pkt), e_hpkt);
        chk("R9 host_rel_valid", int'(host_rel_valid), e_hrel);
        if (e_hrel != 0) chk("R9 host_rel_pkt", int'(host_rel_pkt), e_hpkt);

        @(posedge clk);
        if (e_hrel != 0) void'(q.pop_front());
        if (push) q.push_back(m_pkt);
        m_mode = n_mode; m_pkt = n_pkt; m_off = n_off; m_odd = n_odd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic send_frame(input int nw, input bit odd, input bit crc, input int pkt,
                              input int refuse_at, input int gap);
        for (int k = 0; k < nw; k++)
            step(1, k == 0, k == nw - 1, odd, crc, (pkt << 8) | k, k != refuse_at, pkt, 0);
        idle(gap);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state, queue empty and no interrupt
        ctx = "R8";
        #1;
        chk("R8 reset rx_irq", int'(rx_irq), 0);
        chk("R3 reset mem_we", int'(mem_we), 0);
        idle(2);

        // R1: frame while disabled is ignored
        ctx = "R1";
        rx_enable = 1'b0;
        send_frame(4, 0, 1, 1, -1, 3);
        rx_enable = 1'b1;

        ctx = "R3";
        send_frame(5, 0, 1, 2, -1, 3);
        // R2: crosses the offset-8 page edge; odd length exercises R4
        ctx = "R2";
        send_frame(12, 1, 1, 3, -1, 3);
        ctx = "R6";
        send_frame(4, 0, 0, 4, -1, 3);
        // R5: refused page mid-frame, then refused first allocation
        ctx = "R5";
        send_frame(10, 0, 1, 5, 6, 3);
        send_frame(3, 0, 1, 6, 0, 3);
        // R11: runs past capacity
        ctx = "R11";
        send_frame(31, 0, 1, 7, -1, 3);
        // R10: new start beats during the two header cycles
        ctx = "R10";
        send_frame(3, 1, 1, 8, -1, 0);
        step(1, 1, 1, 0, 1, 16'h0999, 1, 9, 0);
        step(1, 1, 1, 0, 1, 16'h0998, 1, 9, 0);
        idle(3);
        // R9: drain three frames, then remove on empty
        ctx = "R9";
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R9 empty after drain rx_irq", int'(rx_irq), 0);
        idle(1);
        // R7: seventeen good frames into a 16-deep queue
        ctx = "R7";
        for (int f = 0; f < 17; f++) send_frame(2, 0, 1, (10 + f) % 32, -1, 3);
        chk("R7 queue depth", q.size(), 16);
        // R12: drain in completion order
        ctx = "R12";
        for (int i = 0; i < 17; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 1);
        idle(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule